// File: doc/BRIEF.md
# Self-Timed Coarse SAR Conversion Controller

This block sequences the coarse successive-approximation converter of a two-step (zoom) ADC. It decides a parameterised number of bits, five by default, against a capacitor array that uses merged-capacitor switching. During the sampling phase every bottom plate rests at the common-mode level. A rising edge on the conversion-phase input starts a bit loop. The most significant comparison is requested at once, with no plate moved. Each later comparison is launched by the completion strobe of the previous one, not by a per-bit clock. After every decision except the last, one bottom plate moves away from common mode, either up or down.

The comparator is an external asynchronous circuit with a request / done / reset handshake. Its done strobe is resynchronised onto a reference clock. That clock also runs a watchdog: when a comparison stalls, the watchdog forces a default decision so that a metastable comparator cannot hang the loop. The preamplifier enable is held off whenever the block is sampling or idle. A parameter sets the worst-case conversion time, and elaboration rejects any set of parameters whose worst case does not fit inside the budget.

Top module: `sar_async_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `ready`, `result`, `cmp_req`, `cmp_rst`, `preamp_en` and every plate control are 0.
- R2: A rising edge of `conv_phase` has the following effect one clock later: `result` and `ready` are cleared, all plate controls are 0 (all plates at common mode) and `cmp_req` is 1. No plate control changes before the first decision.
- R3: Decisions fill `result` from bit NB-1 down to bit 0, in that order. Each bit holds the value of `cmp_dec` at the moment its done strobe is taken. A decision of 1 gives a result bit of 1.
- R4: The decision for result bit k (k from NB-1 down to 1) drives exactly one of that plate's controls. A decision of 1 sets `plate_dn[k]` and a decision of 0 sets `plate_up[k]`. The LSB decision moves no plate. Both controls of one plate are never set together. Within a conversion a set control stays set.
- R5: `cmp_req` stays high until a done strobe or the watchdog ends the comparison. Between two comparisons `cmp_rst` pulses for exactly one cycle, which gives NB-1 pulses per conversion. `cmp_req` and `cmp_rst` are never high together.
- R6: `ready` rises after the last decision. It then stays high with `cmp_req` and `preamp_en` low until the next rising edge of `conv_phase` or reset.
- R7: One clock after `conv_phase` is sampled low, all plate controls, `cmp_req` and `preamp_en` are 0. A completed `result` and `ready` are kept. A conversion cut short this way leaves `ready` at 0.
- R8: `preamp_en` is high from the start edge until the last decision, and low otherwise.
- R9: A comparison that gets no done strobe within TIMEOUT_CYC clock cycles takes the decision DEFAULT_DEC (0 by default), and the loop goes on with the next bit.
- R10: A conversion completes within CONV_BUDGET_CYC clocks of its start edge. Elaboration fails when the worst case, with every bit timed out, exceeds this budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for sequencing and watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_phase | input | 1 | Conversion phase; low = sampling, rising edge = start |
| cmp_done | input | 1 | Comparator completion strobe (asynchronous, held until `cmp_rst`) |
| cmp_dec | input | 1 | Comparator decision, stable while `cmp_done` is high |
| cmp_req | output | 1 | Request a comparison |
| cmp_rst | output | 1 | Comparator reset pulse between bits |
| preamp_en | output | 1 | Comparator preamplifier enable |
| plate_up | output | NB-1 (bits NB-1:1) | Move plate k to the upper reference |
| plate_dn | output | NB-1 (bits NB-1:1) | Move plate k to the lower reference |
| result | output | NB | Conversion result, MSB first |
| ready | output | 1 | Result valid |

## Verification
The bench runs codes with all ones, all zeros and a lone MSB or LSB, each with a different comparator latency. A design that reversed the bit order or the up/down sense would return mirrored codes or swapped plate controls. Stalls are injected on the MSB and on a middle bit. A missing or badly wired watchdog would hang the run or would leave the wrong bit forced. The bench also drops the conversion phase part-way through a conversion and after a finished one. A design that kept the plates switched or the preamplifier on while sampling would be caught, and so would one that cleared a finished result or flagged a cut-short conversion as ready. It also checks that the plates are untouched when the MSB is requested and that the number of comparator reset pulses is right, which exposes a plate moved before the first decision or a comparator left uncleared between bits.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMP  = 2'd1,
      ST_CRST = 2'd2,
      ST_FIN  = 2'd3
   } sar_state_e;
endpackage

// File: rtl/sar_done_sync.sv
module sar_done_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= (sr << 1) | STAGES'(async_in);
         end
         assign sync_out = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_watchdog.sv
module sar_watchdog #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   assign expire = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!expire) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sar_plate_bank.sv
module sar_plate_bank #(
   parameter int NB = 5,
   localparam int IW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [IW-1:0] idx,
   input  logic          dec,
   output logic [NB-1:1] up,
   output logic [NB-1:1] dn
);
   generate
      for (genvar k = 1; k < NB; k++) begin : g_plate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up[k] <= 1'b0;
               dn[k] <= 1'b0;
            end else if (clear) begin
               up[k] <= 1'b0;
               dn[k] <= 1'b0;
            end else if (load && (idx == IW'(k))) begin
               up[k] <= ~dec;
               dn[k] <= dec;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sar_async_ctrl.sv
module sar_async_ctrl
   import sar_seq_pkg::*;
#(
   parameter int   NB              = 5,
   parameter int   SYNC_STAGES     = 2,
   parameter int   TIMEOUT_CYC     = 64,
   parameter int   CONV_BUDGET_CYC = 400,
   parameter logic DEFAULT_DEC     = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_phase,
   input  logic          cmp_done,
   input  logic          cmp_dec,
   output logic          cmp_req,
   output logic          cmp_rst,
   output logic          preamp_en,
   output logic [NB-1:1] plate_up,
   output logic [NB-1:1] plate_dn,
   output logic [NB-1:0] result,
   output logic          ready
);
   localparam int IW    = $clog2(NB);
   localparam int WORST = NB * TIMEOUT_CYC + (NB - 1) + 1;

   // elaboration-time parameter checks
   if (NB < 2) begin : g_bad_nb
      $error("sar_async_ctrl: NB must be at least 2");
   end
   if (TIMEOUT_CYC < SYNC_STAGES + 3) begin : g_bad_timeout
      $error("sar_async_ctrl: TIMEOUT_CYC too short for the done synchroniser");
   end
   if (WORST > CONV_BUDGET_CYC) begin : g_bad_budget
      $error("sar_async_ctrl: worst-case conversion exceeds CONV_BUDGET_CYC");
   end

   sar_state_e    state;
   logic [IW-1:0] idx;
   logic          conv_q;
   logic          start;
   logic          done_s, done_q, done_evt;
   logic          wd_exp;
   logic          decide;
   logic          dec_use;
   logic          plate_clear;

   assign start = conv_phase && !conv_q;

   sar_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cmp_done),
      .sync_out (done_s)
   );

   assign done_evt = done_s && !done_q;

   sar_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_CMP),
      .expire (wd_exp)
   );

   assign decide      = (state == ST_CMP) && conv_phase && (done_evt || wd_exp);
   assign dec_use     = done_evt ? cmp_dec : DEFAULT_DEC;
   assign plate_clear = start || !conv_phase;

   sar_plate_bank #(.NB(NB)) u_plates (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (plate_clear),
      .load  (decide),
      .idx   (idx),
      .dec   (dec_use),
      .up    (plate_up),
      .dn    (plate_dn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         conv_q <= conv_phase;
         done_q <= done_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         result <= '0;
         ready  <= 1'b0;
      end else if (start) begin
         state  <= ST_CMP;
         idx    <= IW'(NB - 1);
         result <= '0;
         ready  <= 1'b0;
      end else if (!conv_phase) begin
         state  <= ST_IDLE;
      end else begin
         unique case (state)
            ST_CMP: begin
               if (decide) begin
                  result[idx] <= dec_use;
                  if (idx == '0) begin
                     state <= ST_FIN;
                     ready <= 1'b1;
                  end else begin
                     idx   <= idx - 1'b1;
                     state <= ST_CRST;
                  end
               end
            end
            ST_CRST: state <= ST_CMP;
            default: state <= state;
         endcase
      end
   end

   assign cmp_req   = (state == ST_CMP);
   assign cmp_rst   = (state == ST_CRST);
   assign preamp_en = (state == ST_CMP) || (state == ST_CRST);
endmodule

// File: rtl/sar_async_ctrl_chk.sv
module sar_async_ctrl_chk #(
   parameter int NB              = 5,
   parameter int TIMEOUT_CYC     = 64,
   parameter int CONV_BUDGET_CYC = 400
) (
   input logic          clk,
   input logic          rst_n,
   input logic          conv_phase,
   input logic          cmp_req,
   input logic          cmp_rst,
   input logic          preamp_en,
   input logic [NB-1:1] plate_up,
   input logic [NB-1:1] plate_dn,
   input logic [NB-1:0] result,
   input logic          ready
);
   localparam int RW = $clog2(TIMEOUT_CYC + 2);
   localparam int BW = $clog2(CONV_BUDGET_CYC + 2);

   logic          cq;
   logic          act;
   logic [RW-1:0] req_cnt;
   logic [BW-1:0] conv_cnt;
   logic          st_chk;

   assign st_chk = conv_phase && !cq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cq       <= 1'b0;
         act      <= 1'b0;
         req_cnt  <= '0;
         conv_cnt <= '0;
      end else begin
         cq <= conv_phase;
         if (!cmp_req)                       req_cnt <= '0;
         else if (req_cnt != {RW{1'b1}})     req_cnt <= req_cnt + 1'b1;
         if (st_chk) begin
            act      <= 1'b1;
            conv_cnt <= '0;
         end else if (act) begin
            if (ready || !conv_phase)        act <= 1'b0;
            else if (conv_cnt != {BW{1'b1}}) conv_cnt <= conv_cnt + 1'b1;
         end
      end
   end

   assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st_chk |=> (result == '0 && !ready && cmp_req && plate_up == '0 && plate_dn == '0));

   assert_plate_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (plate_up & plate_dn) == '0);

   assert_plate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_phase && cq) |->
         (((plate_up & $past(plate_up)) == $past(plate_up)) &&
          ((plate_dn & $past(plate_dn)) == $past(plate_dn))));

   assert_req_rst_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_req && cmp_rst));

   assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_rst |=> !cmp_rst);

   assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!cmp_req && !preamp_en));

   assert_sampling_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_phase |=> (plate_up == '0 && plate_dn == '0 && !preamp_en && !cmp_req));

   assert_watchdog_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_cnt <= RW'(TIMEOUT_CYC));

   assert_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_cnt <= BW'(CONV_BUDGET_CYC));
endmodule

bind sar_async_ctrl sar_async_ctrl_chk #(
   .NB              (NB),
   .TIMEOUT_CYC     (TIMEOUT_CYC),
   .CONV_BUDGET_CYC (CONV_BUDGET_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_phase (conv_phase),
   .cmp_req    (cmp_req),
   .cmp_rst    (cmp_rst),
   .preamp_en  (preamp_en),
   .plate_up   (plate_up),
   .plate_dn   (plate_dn),
   .result     (result),
   .ready      (ready)
);

// File: tb/sar_async_ctrl_bench.sv
module sar_async_ctrl_bench;
   localparam int NB     = 5;
   localparam int BUDGET = 400;
   localparam int NVEC   = 7;
   // {code[4:0], comparator latency[7:0]}
   localparam logic [12:0] VEC [NVEC] = '{
      {5'b10110, 8'd1}, {5'b01001, 8'd0}, {5'b11111, 8'd3}, {5'b00000, 8'd2},
      {5'b10000, 8'd5}, {5'b00001, 8'd0}, {5'b01110, 8'd4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_phase = 1'b0;
   logic          cmp_done = 1'b0;
   logic          cmp_dec = 1'b0;
   logic          cmp_req, cmp_rst, preamp_en, ready;
   logic [NB-1:1] plate_up, plate_dn;
   logic [NB-1:0] result;

   int checks = 0;
   int errors = 0;

   // behavioural comparator state
   logic [NB-1:0] m_code = '0;
   int            m_dly = 0;
   int            m_cnt = 0;
   int            m_ptr = NB - 1;
   logic          m_req_prev = 1'b0;
   logic          m_stall_en = 1'b0;
   int            m_stall_bit = 0;

   always #10 clk = ~clk;

   sar_async_ctrl u_sar_async_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_phase (conv_phase),
      .cmp_done   (cmp_done),
      .cmp_dec    (cmp_dec),
      .cmp_req    (cmp_req),
      .cmp_rst    (cmp_rst),
      .preamp_en  (preamp_en),
      .plate_up   (plate_up),
      .plate_dn   (plate_dn),
      .result     (result),
      .ready      (ready)
   );

   always @(negedge clk) begin
      if (m_req_prev && !cmp_req) m_ptr <= m_ptr - 1;
      m_req_prev <= cmp_req;
      if (!cmp_req || cmp_rst) begin
         cmp_done <= 1'b0;
         m_cnt    <= 0;
      end else if (!cmp_done && !(m_stall_en && m_ptr == m_stall_bit)) begin
         if (m_cnt >= m_dly) begin
            cmp_done <= 1'b1;
            cmp_dec  <= m_code[m_ptr];
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic convert(input logic [NB-1:0] code, input int dly, input bit stall,
                          input int sbit, input logic [NB-1:0] exp);
      int cyc;
      int rst_pulses;
      m_code = code; m_dly = dly; m_stall_en = stall; m_stall_bit = sbit;
      conv_phase = 1'b0;
      repeat (3) @(negedge clk);
      m_ptr = NB - 1;
      conv_phase = 1'b1;
      @(negedge clk);
      // R2: one clock after the start edge
      chk(cmp_req && result == '0 && !ready, "R2 start clears result and requests MSB",
          32'({cmp_req, ready, result}), 32'({1'b1, 1'b0, 5'b0}));
      chk(plate_up == '0 && plate_dn == '0, "R2 no plate moved before MSB decision",
          32'({plate_up, plate_dn}), 32'h0);
      chk(preamp_en, "R8 preamp on during conversion", 32'(preamp_en), 32'h1);
      cyc = 1;
      rst_pulses = 0;
      while (!ready && cyc < 2000) begin
         @(negedge clk);
         if (cmp_rst) rst_pulses++;
         cyc++;
      end
      chk(result == exp, "R3 result code", 32'(result), 32'(exp));
      chk(plate_dn == exp[NB-1:1] && plate_up == ~exp[NB-1:1], "R4 plate controls",
          32'({plate_up, plate_dn}), 32'({~exp[NB-1:1], exp[NB-1:1]}));
      chk(rst_pulses == NB - 1, "R5 comparator reset pulses", 32'(rst_pulses), 32'(NB - 1));
      chk(cyc <= BUDGET, "R10 conversion within budget", 32'(cyc), 32'(BUDGET));
      repeat (3) @(negedge clk);
      chk(ready && !cmp_req && !preamp_en, "R6 ready held, comparator quiet",
          32'({ready, cmp_req, preamp_en}), 32'({1'b1, 1'b0, 1'b0}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!ready && result == '0 && !cmp_req && !cmp_rst && !preamp_en &&
          plate_up == '0 && plate_dn == '0, "R1 reset state",
          32'({ready, result, cmp_req, cmp_rst, preamp_en, plate_up, plate_dn}), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!ready && !cmp_req && !preamp_en, "R1 idle after reset release",
          32'({ready, cmp_req, preamp_en}), 32'h0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         convert(VEC[i][12:8], int'(VEC[i][7:0]), 1'b0, 0, VEC[i][12:8]);
      end

      // R7: sampling after a completed conversion keeps result, releases plates
      conv_phase = 1'b0;
      @(negedge clk);
      chk(plate_up == '0 && plate_dn == '0 && !preamp_en && !cmp_req,
          "R7 sampling returns plates to common mode",
          32'({plate_up, plate_dn, preamp_en, cmp_req}), 32'h0);
      chk(ready && result == 5'b01110, "R7 completed result retained while sampling",
          32'({ready, result}), 32'({1'b1, 5'b01110}));

      // R9: stall on a middle bit, forced to default decision 0
      convert(5'b11111, 1, 1'b1, 2, 5'b11011);
      chk(plate_up[2] && !plate_dn[2], "R9 stalled bit 2 plate takes default",
          32'({plate_up[2], plate_dn[2]}), 32'b10);
      // R9: stall on the MSB
      convert(5'b10101, 0, 1'b1, 4, 5'b00101);

      // R7: cut a conversion short
      m_code = 5'b11100; m_dly = 6; m_stall_en = 1'b0;
      conv_phase = 1'b0;
      repeat (3) @(negedge clk);
      m_ptr = NB - 1;
      conv_phase = 1'b1;
      repeat (15) @(negedge clk);
      conv_phase = 1'b0;
      @(negedge clk);
      chk(!ready && !cmp_req && !preamp_en && plate_up == '0 && plate_dn == '0,
          "R7 aborted conversion not ready, plates released",
          32'({ready, cmp_req, preamp_en, plate_up, plate_dn}), 32'h0);
      repeat (4) @(negedge clk);
      chk(!ready, "R7 aborted conversion stays not ready", 32'(ready), 32'h0);

      // fresh conversion after abort
      convert(5'b01011, 2, 1'b0, 0, 5'b01011);
      summary();
   end
endmodule